// File: doc/BRIEF.md
# Cache Mode Write-Policy Controller

This block makes the per-access policy decision for a two-level cache. It sits beside the tag lookup. For every access it receives these inputs:

- the two cache-control mode bits: cache disable and no-write-through;
- the page attributes that apply to the access: page cache disable and page write-through;
- the external write-back/write-through sample;
- the access direction;
- the first- and second-level hit indications;
- the current MESI state of the line.

One cycle later it reports five results: whether a line fill is wanted, whether external memory is written, whether the cached copy is written, the line's next MESI state, and a general-protection fault for the one illegal mode pair.

The page attributes are taken by the caller from whichever page-table or page-directory entry governs the access. Four mode pairs are recognised:

- **Normal.** Cache disable low and no-write-through low. The cache runs write-back.
- **No-fill.** Cache disable high and no-write-through low. Cached contents are still used and written, but no line is filled.
- **Frozen.** Both bits high. Cached contents are still used and written, but no line is filled, and write hits never reach external memory.
- **Illegal.** Cache disable low and no-write-through high. This pair faults instead of performing the access.

Top module: `cache_wpolicy_ctl`

## Requirements
- R1: With cache disable 0 and no-write-through 1, the result has gp_fault=1, fill_req=0, ext_write=0, cache_update=0, and next_state equal to the incoming line state.
- R2: A result appears with res_valid=1 exactly one clock after acc_valid=1 is sampled. While res_valid=0, including after reset, every result flag and next_state are 0.
- R3: A line counts as a hit only when l1_hit or l2_hit is 1 and its state is not Invalid. The state encoding is I=00, S=01, E=10, M=11.
- R4: In normal mode, a read miss sets fill_req exactly when pcd=0. A read never writes external memory, never updates the cache, and leaves the state unchanged.
- R5: In normal or no-fill mode, a write hit on an E or M line sets cache_update. With pwt=0 the line becomes M and there is no external write. With pwt=1 it writes external memory and keeps its state.
- R6: In normal or no-fill mode, a write hit on an S line sets cache_update and ext_write. The line becomes E when pwt=0 and the write-back sample wbwt=1, and otherwise stays S.
- R7: With cache disable 1, fill_req is never set, for reads or writes.
- R8: In frozen mode, a write hit sets cache_update with no external write. E becomes M, while S and M keep their state.
- R9: In any legal mode, a write miss sets ext_write only, with no fill and no cache update, and leaves the state unchanged.
- R10: No decision moves a line from S, E or M into Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe; inputs are sampled when high |
| cd | input | 1 | Cache-disable mode bit |
| nw | input | 1 | No-write-through mode bit |
| pcd | input | 1 | Page cache-disable attribute for this access |
| pwt | input | 1 | Page write-through attribute for this access |
| wbwt | input | 1 | External write-back/write-through sample (1 = write-back allowed) |
| is_write | input | 1 | 1 = write access, 0 = read |
| l1_hit | input | 1 | First-level tag match |
| l2_hit | input | 1 | Second-level tag match |
| line_state | input | 2 | Current MESI state of the line |
| res_valid | output | 1 | Result valid, one cycle after acc_valid |
| fill_req | output | 1 | Request a line fill |
| ext_write | output | 1 | Issue an external memory write |
| cache_update | output | 1 | Write the cached copy |
| next_state | output | 2 | MESI state to store back |
| gp_fault | output | 1 | Illegal mode-pair fault |

## Verification
The bench drives the entire input space: every mode pair, both directions, all four hit-flag pairs, every MESI state, and all eight settings of the page-attribute and write-back-sample bits. This separates the four modes from one another. Hit flags paired with an Invalid state show whether a stale tag match is wrongly taken as a hit. The pwt and wbwt settings show which write hits go through to memory and which Shared lines are promoted. Idle gaps placed between accesses show whether the result flags clear when no access is in flight.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    MESI_I = 2'b00,
    MESI_S = 2'b01,
    MESI_E = 2'b10,
    MESI_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    MODE_NORMAL,
    MODE_NOFILL,
    MODE_FROZEN,
    MODE_ILLEGAL
  } mode_t;

  typedef struct packed {
    logic  fill;
    logic  ext_wr;
    logic  upd;
    mesi_t nxt;
    logic  fault;
  } verdict_t;
endpackage

// File: rtl/cwp_mode_decode.sv
module cwp_mode_decode
  import cwp_pkg::*;
(
  input  logic  cd,
  input  logic  nw,
  output mode_t mode
);
  always_comb begin
    unique case ({cd, nw})
      2'b00:   mode = MODE_NORMAL;
      2'b01:   mode = MODE_ILLEGAL;
      2'b10:   mode = MODE_NOFILL;
      default: mode = MODE_FROZEN;
    endcase
  end
endmodule

// File: rtl/cwp_read_policy.sv
module cwp_read_policy
  import cwp_pkg::*;
(
  input  mode_t    mode,
  input  logic     hit,
  input  logic     pcd,
  input  mesi_t    state,
  output verdict_t v
);
  always_comb begin
    v        = '0;
    v.nxt    = state;
    // only the normal mode may allocate, and only for cacheable pages
    v.fill   = (mode == MODE_NORMAL) && !hit && !pcd;
  end
endmodule

// File: rtl/cwp_write_policy.sv
module cwp_write_policy
  import cwp_pkg::*;
(
  input  mode_t    mode,
  input  logic     hit,
  input  logic     pwt,
  input  logic     wbwt,
  input  mesi_t    state,
  output verdict_t v
);
  always_comb begin
    v     = '0;
    v.nxt = state;
    if (!hit) begin
      v.ext_wr = 1'b1;
    end else begin
      v.upd = 1'b1;
      if (mode == MODE_FROZEN) begin
        if (state == MESI_E) v.nxt = MESI_M;
      end else begin
        unique case (state)
          MESI_S: begin
            v.ext_wr = 1'b1;
            if (!pwt && wbwt) v.nxt = MESI_E;
          end
          default: begin
            if (pwt) v.ext_wr = 1'b1;
            else     v.nxt    = MESI_M;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cache_wpolicy_ctl.sv
module cache_wpolicy_ctl
  import cwp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic               cd,
  input  logic               nw,
  input  logic               pcd,
  input  logic               pwt,
  input  logic               wbwt,
  input  logic               is_write,
  input  logic               l1_hit,
  input  logic               l2_hit,
  input  logic [STATE_W-1:0] line_state,
  output logic               res_valid,
  output logic               fill_req,
  output logic               ext_write,
  output logic               cache_update,
  output logic [STATE_W-1:0] next_state,
  output logic               gp_fault
);
  mode_t    mode;
  mesi_t    cur;
  logic     hit;
  verdict_t rd_v, wr_v, pick, held;

  assign cur = mesi_t'(line_state);
  assign hit = (l1_hit || l2_hit) && (cur != MESI_I);

  cwp_mode_decode u_mode (.cd(cd), .nw(nw), .mode(mode));

  cwp_read_policy u_rd (
    .mode(mode), .hit(hit), .pcd(pcd), .state(cur), .v(rd_v)
  );

  cwp_write_policy u_wr (
    .mode(mode), .hit(hit), .pwt(pwt), .wbwt(wbwt), .state(cur), .v(wr_v)
  );

  always_comb begin
    if (mode == MODE_ILLEGAL) begin
      pick       = '0;
      pick.nxt   = cur;
      pick.fault = 1'b1;
    end else begin
      pick = is_write ? wr_v : rd_v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      held      <= '0;
    end else begin
      res_valid <= acc_valid;
      held      <= acc_valid ? pick : '0;
    end
  end

  assign fill_req     = held.fill;
  assign ext_write    = held.ext_wr;
  assign cache_update = held.upd;
  assign next_state   = held.nxt;
  assign gp_fault     = held.fault;

  // R1
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    gp_fault |-> !(fill_req || ext_write || cache_update));

  // R2
  result_timing_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  // R4 R7
  fill_source_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && (cd || is_write) |=> !fill_req);

  // R8
  frozen_hit_no_ext_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && cd && nw && is_write && (l1_hit || l2_hit) && (line_state != 2'b00)
      |=> !ext_write && cache_update);

  // R10
  never_invalidate_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && (line_state != 2'b00) |=> next_state != 2'b00);
endmodule

// File: tb/cache_wpolicy_ctl_test.sv
module cache_wpolicy_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0, cd = 1'b0, nw = 1'b0, pcd = 1'b0, pwt = 1'b0, wbwt = 1'b0;
  logic is_write = 1'b0, l1_hit = 1'b0, l2_hit = 1'b0;
  logic [1:0] line_state = 2'b00;
  logic res_valid, fill_req, ext_write, cache_update, gp_fault;
  logic [1:0] next_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit armed = 1'b0;

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  cache_wpolicy_ctl uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .cd(cd), .nw(nw),
    .pcd(pcd), .pwt(pwt), .wbwt(wbwt), .is_write(is_write),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .line_state(line_state),
    .res_valid(res_valid), .fill_req(fill_req), .ext_write(ext_write),
    .cache_update(cache_update), .next_state(next_state), .gp_fault(gp_fault)
  );

  // Reference: {fill, ext, upd, nxt[1:0], fault}, states I=00 S=01 E=10 M=11
  function automatic logic [5:0] ref_model(logic c, logic n, logic w, logic h1,
      logic h2, logic [1:0] st, logic pc, logic pw, logic wb);
    logic hit, fl, ex, up, ft;
    logic [1:0] nx;
    hit = (h1 | h2) && st != 2'b00;
    fl = 0; ex = 0; up = 0; ft = 0; nx = st;
    if (!c && n) ft = 1;
    else if (!w) begin
      if (!hit && !c && !pc) fl = 1;
    end else if (!hit) ex = 1;
    else begin
      up = 1;
      if (c && n) begin
        if (st == 2'b10) nx = 2'b11;
      end else if (st == 2'b01) begin
        ex = 1;
        if (!pw && wb) nx = 2'b10;
      end else if (pw) ex = 1;
      else nx = 2'b11;
    end
    return {fl, ex, up, nx, ft};
  endfunction

  function automatic string tag_of(logic c, logic n, logic w, logic h1,
      logic h2, logic [1:0] st);
    if (!c && n) return "R1";
    if ((h1 | h2) && st == 2'b00) return "R3";
    if (!w) return (c ? "R7" : ((h1 | h2) ? "R10" : "R4"));
    if (!(h1 | h2)) return "R9";
    if (c && n) return "R8";
    if (st == 2'b01) return "R6";
    return "R5";
  endfunction

  task automatic drive(logic c, logic n, logic w, logic h1, logic h2,
      logic [1:0] st, logic pc, logic pw, logic wb);
    item_t it;
    acc_valid = 1; cd = c; nw = n; is_write = w; l1_hit = h1; l2_hit = h2;
    line_state = st; pcd = pc; pwt = pw; wbwt = wb;
    it.exp = ref_model(c, n, w, h1, h2, st, pc, pw, wb);
    it.tag = tag_of(c, n, w, h1, h2, st);
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle();
    acc_valid = 0;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (armed && !done) begin
      if (res_valid) begin
        item_t it;
        logic [5:0] got;
        got = {fill_req, ext_write, cache_update, next_state, gp_fault};
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected result got=%b expected=none", got);
        end else begin
          it = q.pop_front();
          if (got !== it.exp) begin
            errors++;
            $display("FAIL %s got=%b expected=%b", it.tag, got, it.exp);
          end
        end
      end else begin
        // R2: quiet outputs when no result is in flight
        checks++;
        if ({fill_req, ext_write, cache_update, next_state, gp_fault} !== 6'b0) begin
          errors++;
          $display("FAIL R2 idle outputs got=%b expected=000000",
                   {fill_req, ext_write, cache_update, next_state, gp_fault});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2: reset state
    checks++;
    if ({res_valid, fill_req, ext_write, cache_update, next_state, gp_fault} !== 7'b0) begin
      errors++;
      $display("FAIL R2 reset got=%b expected=0000000",
               {res_valid, fill_req, ext_write, cache_update, next_state, gp_fault});
    end
    armed = 1;
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int h = 0; h < 4; h++)
          for (int st = 0; st < 4; st++)
            for (int a = 0; a < 8; a++) begin
              drive(m[1], m[0], w[0], h[1], h[0], st[1:0], a[2], a[1], a[0]);
              n++;
              if (n % 37 == 0) idle();
            end
    idle();
    idle();
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results got=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule